// File: doc/BRIEF.md
# Operand Bypass and Pipeline Interlock Controller

This block steers operands and controls stalls and flushes in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It compares the source register numbers of the instruction in execute against the destinations of the two older instructions still in flight. From that it picks, for each ALU operand, whether the value comes from the register file, from the execute/memory pipeline register, or from the memory/writeback pipeline register. The datapath registers and the ALU are outside the block.

The block also watches for a load in execute whose destination is a source of the instruction in decode. A loaded value arrives too late to be bypassed into the next execute cycle. In that case the block holds the program counter and the fetch/decode register for one cycle and sends a cleared no-op into decode/execute. Branches are predicted not taken and resolved at the end of decode, so a misprediction discards only the single instruction fetched behind the branch. The register file writes early in the cycle and reads late. An instruction three places behind its producer therefore reads the new value directly, and the block never bypasses from writeback into decode.

The whole block is combinational. Parameters set the register-number width, the number of source operands and whether register 0 is hard-wired to zero.

Top module: `hzu_core`

## Requirements
- R1: When the execute/memory destination is write-enabled and equals an operand's source register, that operand's select is 1, meaning the execute/memory value (2 bits per operand: 0 register file, 1 execute/memory, 2 memory/writeback; operand k occupies bits 2k+1:2k).
- R2: When only the memory/writeback destination is write-enabled and matches an operand's source, that operand's select is 2.
- R3: When both older destinations match the same source, the execute/memory value wins and the select is 1.
- R4: With no write-enabled match, the select is 0 and the operand is read from the register file. This also covers a producer that has already left writeback.
- R5: With register 0 hard-wired (the default), a source of 0 always gets select 0, whatever the destinations are.
- R6: A load in execute whose non-zero destination equals either decode source (operand k at bits AW*(k+1)-1:AW*k) raises the stall in the same cycle.
- R7: The PC hold, the fetch/decode hold and the decode/execute bubble are always asserted together, and each lasts exactly as long as the load-use condition.
- R8: A non-load instruction in execute, or a load whose destination is register 0, never causes a stall.
- R9: A branch misprediction raises the squash of the fetch/decode instruction in the same cycle when no stall is present.
- R10: A misprediction that coincides with a stall does not squash, because the branch in decode has not yet made its final decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_flat | input | NUM_SRC*REG_AW | Source register numbers of the instruction in decode |
| ex_src_flat | input | NUM_SRC*REG_AW | Source register numbers of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a memory load |
| ex_rd | input | REG_AW | Destination register of the instruction in execute |
| mem_rd | input | REG_AW | Destination in the execute/memory pipeline register |
| mem_wen | input | 1 | Execute/memory instruction writes a register |
| wb_rd | input | REG_AW | Destination in the memory/writeback pipeline register |
| wb_wen | input | 1 | Memory/writeback instruction writes a register |
| br_mispredict | input | 1 | Branch in decode resolved as taken (predicted not taken) |
| fwd_sel_flat | output | 2*NUM_SRC | Per-operand bypass select |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a cleared no-op into decode/execute |
| ifid_squash | output | 1 | Discard the instruction in fetch/decode |

## Verification
The hardest situation to reach is a misprediction that lands in the same cycle as a load-use stall. Separately, the priority case needs both older destinations to match one source while register 0 and the write enables still interact. The stimulus sweeps every combination of source, both destinations and both write enables over an 8-register configuration, so every priority and zero-register case is reached. A second sweep crosses every decode source pair with every load destination and toggles the mispredict input along a pattern. That pattern guarantees mispredicts both with and without a concurrent stall.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
   typedef enum logic [1:0] {
      FWD_RF    = 2'd0,
      FWD_EXMEM = 2'd1,
      FWD_MEMWB = 2'd2
   } fwd_sel_e;
   localparam int FWD_SEL_W = 2;
endpackage

// File: rtl/hzu_match.sv
module hzu_match #(
   parameter int REG_AW     = 5,
   parameter bit ZERO_FIXED = 1'b1
) (
   input  logic [REG_AW-1:0] rd,
   input  logic              we,
   input  logic [REG_AW-1:0] src,
   output logic              hit
);
   generate
      if (ZERO_FIXED) begin : g_zero_fixed
         assign hit = we && (rd == src) && (|rd);
      end else begin : g_zero_plain
         assign hit = we && (rd == src);
      end
   endgenerate
endmodule

// File: rtl/hzu_fwd_pick.sv
module hzu_fwd_pick
   import hzu_pkg::*;
#(
   parameter int REG_AW     = 5,
   parameter bit ZERO_FIXED = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_wen,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_wen,
   output fwd_sel_e          sel
);
   logic hit_mem, hit_wb;

   hzu_match #(.REG_AW(REG_AW), .ZERO_FIXED(ZERO_FIXED)) u_hit_mem (
      .rd(mem_rd), .we(mem_wen), .src(src), .hit(hit_mem));
   hzu_match #(.REG_AW(REG_AW), .ZERO_FIXED(ZERO_FIXED)) u_hit_wb (
      .rd(wb_rd), .we(wb_wen), .src(src), .hit(hit_wb));

   always_comb begin
      if (hit_mem)     sel = FWD_EXMEM;
      else if (hit_wb) sel = FWD_MEMWB;
      else             sel = FWD_RF;
   end
endmodule

// File: rtl/hzu_load_interlock.sv
module hzu_load_interlock #(
   parameter int REG_AW     = 5,
   parameter int NUM_SRC    = 2,
   parameter bit ZERO_FIXED = 1'b1
) (
   input  logic                      ex_is_load,
   input  logic [REG_AW-1:0]         ex_rd,
   input  logic [NUM_SRC*REG_AW-1:0] id_src_flat,
   output logic                      stall
);
   logic [NUM_SRC-1:0] hits;

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
         hzu_match #(.REG_AW(REG_AW), .ZERO_FIXED(ZERO_FIXED)) u_hit (
            .rd (ex_rd),
            .we (ex_is_load),
            .src(id_src_flat[k*REG_AW +: REG_AW]),
            .hit(hits[k]));
      end
   endgenerate

   assign stall = |hits;
endmodule

// File: rtl/hzu_core.sv
module hzu_core
   import hzu_pkg::*;
#(
   parameter int REG_AW     = 5,
   parameter int NUM_SRC    = 2,
   parameter bit ZERO_FIXED = 1'b1
) (
   input  logic [NUM_SRC*REG_AW-1:0]    id_src_flat,
   input  logic [NUM_SRC*REG_AW-1:0]    ex_src_flat,
   input  logic                         ex_is_load,
   input  logic [REG_AW-1:0]            ex_rd,
   input  logic [REG_AW-1:0]            mem_rd,
   input  logic                         mem_wen,
   input  logic [REG_AW-1:0]            wb_rd,
   input  logic                         wb_wen,
   input  logic                         br_mispredict,
   output logic [NUM_SRC*FWD_SEL_W-1:0] fwd_sel_flat,
   output logic                         pc_hold,
   output logic                         ifid_hold,
   output logic                         idex_bubble,
   output logic                         ifid_squash
);
   localparam int SRC_BITS = NUM_SRC * REG_AW;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hzu_core: REG_AW must lie in 1..8");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_src
         $error("hzu_core: NUM_SRC must lie in 1..4");
      end
      if (SRC_BITS < 1) begin : g_bad_bits
         $error("hzu_core: empty source bus");
      end
   endgenerate

   logic load_use;

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
         fwd_sel_e sel_k;
         hzu_fwd_pick #(.REG_AW(REG_AW), .ZERO_FIXED(ZERO_FIXED)) u_pick (
            .src    (ex_src_flat[k*REG_AW +: REG_AW]),
            .mem_rd (mem_rd),
            .mem_wen(mem_wen),
            .wb_rd  (wb_rd),
            .wb_wen (wb_wen),
            .sel    (sel_k));
         assign fwd_sel_flat[k*FWD_SEL_W +: FWD_SEL_W] = sel_k;
      end
   endgenerate

   hzu_load_interlock #(
      .REG_AW(REG_AW), .NUM_SRC(NUM_SRC), .ZERO_FIXED(ZERO_FIXED)
   ) u_interlock (
      .ex_is_load (ex_is_load),
      .ex_rd      (ex_rd),
      .id_src_flat(id_src_flat),
      .stall      (load_use));

   assign pc_hold     = load_use;
   assign ifid_hold   = load_use;
   assign idex_bubble = load_use;
   assign ifid_squash = br_mispredict & ~load_use;
endmodule

// File: rtl/hzu_core_chk.sv
module hzu_core_chk #(
   parameter int REG_AW     = 5,
   parameter int NUM_SRC    = 2,
   parameter bit ZERO_FIXED = 1'b1
) (
   input logic [NUM_SRC*REG_AW-1:0] ex_src_flat,
   input logic                      ex_is_load,
   input logic                      mem_wen,
   input logic                      wb_wen,
   input logic                      br_mispredict,
   input logic [NUM_SRC*2-1:0]      fwd_sel_flat,
   input logic                      pc_hold,
   input logic                      ifid_hold,
   input logic                      idex_bubble,
   input logic                      ifid_squash
);
   always_comb begin
      AST_HOLD_TRIO: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble); // R7
      AST_STALL_NEEDS_LOAD: assert (!pc_hold || ex_is_load); // R8
      AST_SQUASH_NEEDS_MISP: assert (!ifid_squash || br_mispredict); // R9
      AST_NO_SQUASH_IN_STALL: assert (!(ifid_squash && idex_bubble)); // R10
      for (int k = 0; k < NUM_SRC; k++) begin
         AST_SEL_LEGAL: assert (fwd_sel_flat[2*k +: 2] != 2'd3); // R4
         AST_EXMEM_NEEDS_WEN: assert (fwd_sel_flat[2*k +: 2] != 2'd1 || mem_wen); // R1
         AST_MEMWB_NEEDS_WEN: assert (fwd_sel_flat[2*k +: 2] != 2'd2 || wb_wen); // R2
         AST_ZERO_NO_FWD: assert (!ZERO_FIXED || (|ex_src_flat[k*REG_AW +: REG_AW])
                                  || fwd_sel_flat[2*k +: 2] == 2'd0); // R5
      end
   end
endmodule

bind hzu_core hzu_core_chk #(
   .REG_AW(REG_AW), .NUM_SRC(NUM_SRC), .ZERO_FIXED(ZERO_FIXED)
) u_chk (
   .ex_src_flat  (ex_src_flat),
   .ex_is_load   (ex_is_load),
   .mem_wen      (mem_wen),
   .wb_wen       (wb_wen),
   .br_mispredict(br_mispredict),
   .fwd_sel_flat (fwd_sel_flat),
   .pc_hold      (pc_hold),
   .ifid_hold    (ifid_hold),
   .idex_bubble  (idex_bubble),
   .ifid_squash  (ifid_squash)
);

// File: tb/test_hzu_core.sv
module test_hzu_core;
   localparam int AW = 3;
   localparam int NS = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [NS*AW-1:0] id_src_flat, ex_src_flat;
   logic             ex_is_load, mem_wen, wb_wen, br_mispredict;
   logic [AW-1:0]    ex_rd, mem_rd, wb_rd;
   logic [NS*2-1:0]  fwd_sel_flat;
   logic             pc_hold, ifid_hold, idex_bubble, ifid_squash;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   hzu_core #(.REG_AW(AW), .NUM_SRC(NS), .ZERO_FIXED(1'b1)) i_hzu_core (
      .id_src_flat(id_src_flat), .ex_src_flat(ex_src_flat),
      .ex_is_load(ex_is_load), .ex_rd(ex_rd),
      .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
      .br_mispredict(br_mispredict), .fwd_sel_flat(fwd_sel_flat),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
      .ifid_squash(ifid_squash));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_sel(int s, int m, bit me, int w, bit we);
      if (me && m != 0 && m == s) return 1;
      if (we && w != 0 && w == s) return 2;
      return 0;
   endfunction

   function automatic string sel_tag(int s, int m, bit me, int w, bit we);
      bit hm = me && m == s && s != 0;
      bit hw = we && w == s && s != 0;
      if (s == 0 && ((me && m == 0) || (we && w == 0))) return "R5";
      if (hm && hw) return "R3";
      if (hm) return "R1";
      if (hw) return "R2";
      return "R4";
   endfunction

   task automatic drive_idle();
      id_src_flat = '0; ex_src_flat = '0; ex_is_load = 1'b0; ex_rd = '0;
      mem_rd = '0; mem_wen = 1'b0; wb_rd = '0; wb_wen = 1'b0; br_mispredict = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      drive_idle();
      @(negedge clk);
      // idle state: register-file operands, no hold, no squash (R4, R7, R9)
      chk(fwd_sel_flat == '0, "R4", int'(fwd_sel_flat), 0);
      chk(!pc_hold && !ifid_hold && !idex_bubble, "R7", int'(pc_hold), 0);
      chk(!ifid_squash, "R9", int'(ifid_squash), 0);

      // bypass sweep over every source / destination / enable combination
      for (int s = 0; s < 8; s++)
         for (int m = 0; m < 8; m++)
            for (int w = 0; w < 8; w++)
               for (int e = 0; e < 4; e++) begin
                  int s1;
                  s1 = (s + 3) % 8;
                  @(posedge clk); #1;
                  drive_idle();
                  ex_src_flat = {AW'(s1), AW'(s)};
                  mem_rd = AW'(m); mem_wen = e[0];
                  wb_rd = AW'(w);  wb_wen = e[1];
                  @(negedge clk);
                  chk(int'(fwd_sel_flat[1:0]) == exp_sel(s, m, e[0], w, e[1]),
                      sel_tag(s, m, e[0], w, e[1]), int'(fwd_sel_flat[1:0]),
                      exp_sel(s, m, e[0], w, e[1]));
                  chk(int'(fwd_sel_flat[3:2]) == exp_sel(s1, m, e[0], w, e[1]),
                      sel_tag(s1, m, e[0], w, e[1]), int'(fwd_sel_flat[3:2]),
                      exp_sel(s1, m, e[0], w, e[1]));
               end

      // load-use and squash sweep
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++)
            for (int r = 0; r < 8; r++)
               for (int ld = 0; ld < 2; ld++) begin
                  bit st, mp;
                  string tg;
                  mp = ((a + b + r + ld) % 3) != 0;
                  st = (ld == 1) && (r != 0) && (r == a || r == b);
                  tg = (ld == 0 || r == 0) ? "R8" : "R6";
                  @(posedge clk); #1;
                  drive_idle();
                  id_src_flat = {AW'(b), AW'(a)};
                  ex_rd = AW'(r); ex_is_load = ld[0]; br_mispredict = mp;
                  @(negedge clk);
                  chk(pc_hold == st, tg, int'(pc_hold), int'(st));
                  chk(ifid_hold == st && idex_bubble == st, "R7",
                      int'({ifid_hold, idex_bubble}), st ? 3 : 0);
                  chk(ifid_squash == (mp && !st), st ? "R10" : "R9",
                      int'(ifid_squash), int'(mp && !st));
               end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule